// File: doc/BRIEF.md
# I2C Bus Master with Power-On EEPROM Loader

This block is the only master on a two-wire I2C bus. It drives SCL and SDA through output enables on open-drain pads with external pull-ups: an enable of 1 pulls the line low, and an enable of 0 releases it so that it reads high. A released SCL that a slave keeps low stretches the current clock, and the master waits for it.

After reset, a built-in loader owns the bus while it holds the downstream processor in reset. The loader sets the EEPROM word pointer to zero, then reads `BOOT_BYTES` bytes into a configuration vector. If the device does not acknowledge its address, the loader keeps the default configuration. When the loader has finished, it releases the processor reset and hands the same byte engine to a command port. On that port the processor can issue START, STOP, write-byte and read-byte commands.

The SCL high and low phases each last `HALF_CYC` system clocks, not counting stretching.

Top module: `i2c_boot_master`

## Requirements
- R1: While reset is asserted, and right after it, `cpu_rst_o` is 1, `busy_o` is 1 and both `scl_oe_o` and `sda_oe_o` are 0.
- R2: After reset, the loader runs this sequence on the bus:
  - START;
  - byte `{DEV_ADDR,0}` (ACKed);
  - byte 0x00;
  - repeated START;
  - byte `{DEV_ADDR,1}`;
  - `BOOT_BYTES` read bytes, each ACKed by the master except the last, which gets a NACK;
  - STOP.

  Read byte k is placed in `cfg_o[8k+7:8k]`. Only after the STOP does `cpu_rst_o` go to 0.
- R3: If the first address byte gets a NACK, the loader issues STOP at once. `cfg_o` then equals `CFG_DEFAULT`, and `cpu_rst_o` goes to 0.
- R4: SDA changes only while SCL is low, with two exceptions: a START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high.
- R5: After releasing SCL, the master waits until the synchronised SCL reads high. Only then does it count the `HALF_CYC` high phase, so every SCL high pulse lasts at least `HALF_CYC` clocks even when a slave stretches the clock.
- R6: A write command shifts `wdata_i` out MSB first over eight clocks and releases SDA on the ninth clock. `ack_o` is then 1 if SDA was low (ACK) and 0 if it was high (NACK).
- R7: A read command samples eight bits MSB first into `rdata_o`. On the ninth clock the master pulls SDA low when `last_i` is 0 and releases it when `last_i` is 1.
- R8: A START command produces a START condition, including a repeated START in the middle of a transfer. A STOP command produces a STOP condition and leaves both enables at 0.
- R9: While `cpu_rst_o` is 1, the command inputs are ignored: they put nothing on the bus and `done_o` stays 0 after the boot.
- R10: `done_o` reads 0 in the cycle after a command is accepted. It reads 1 once the command has completed, and `busy_o` is 0 at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cpu_rst_o | output | 1 | Processor reset, held at 1 while booting |
| cfg_o | output | BOOT_BYTES*8 | Configuration loaded at boot, byte k at bits 8k+7:8k |
| start_i | input | 1 | Command: START (highest priority) |
| stop_i | input | 1 | Command: STOP |
| wr_i | input | 1 | Command: write `wdata_i` |
| rd_i | input | 1 | Command: read a byte (lowest priority) |
| last_i | input | 1 | For reads: 1 sends NACK after the byte |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Last byte read |
| ack_o | output | 1 | 1 if the slave acknowledged the last write |
| done_o | output | 1 | Sticky completion flag, cleared by a new command |
| busy_o | output | 1 | Loader active or engine running |

## Verification
A wrong bit counter or shift state in the engine shows up on the bus as a ninth-clock slot in the wrong place, a misframed byte or a bad ACK. The bus monitor reports it when that byte's acknowledge clock ends. A stretch-handling fault shows up as an SCL high pulse shorter than `HALF_CYC` at the very next falling edge. A loader step fault shows up as a scoreboard mismatch at the first wrong condition, or as a wrong `cfg_o` when `cpu_rst_o` falls.

// File: rtl/i2c_boot_pkg.sv
package i2c_boot_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WR, OP_RD} i2c_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL} eng_st_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/i2c_byte_eng.sv
module i2c_byte_eng
  import i2c_boot_pkg::*;
#(
  parameter int HALF_CYC = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  i2c_op_e    cmd_op_i,
  input  logic [7:0] cmd_wdata_i,
  input  logic       cmd_last_i,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       ack_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] CNT_END = CW'(HALF_CYC - 1);

  eng_st_e       st_q;
  i2c_op_e       op_q;
  logic [7:0]    sh_q;
  logic          last_q;
  logic [3:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic          scl_oe_q, sda_oe_q, ack_q, done_q;
  logic          sda_low_want;

  always_comb begin
    unique case (op_q)
      OP_START: sda_low_want = 1'b0;
      OP_STOP:  sda_low_want = 1'b1;
      OP_WR:    sda_low_want = (bit_q < 4'd8) ? !sh_q[7] : 1'b0;
      default:  sda_low_want = (bit_q < 4'd8) ? 1'b0 : !last_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_START;
      sh_q     <= '0;
      last_q   <= 1'b0;
      bit_q    <= '0;
      cnt_q    <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          op_q     <= cmd_op_i;
          sh_q     <= cmd_wdata_i;
          last_q   <= cmd_last_i;
          bit_q    <= '0;
          cnt_q    <= '0;
          scl_oe_q <= 1'b1;
          st_q     <= ST_LOW;
        end
        ST_LOW: begin
          // SDA moves one cycle after SCL falls
          if (cnt_q == '0) sda_oe_q <= sda_low_want;
          if (cnt_q == CNT_END) begin
            cnt_q    <= '0;
            scl_oe_q <= 1'b0;
            st_q     <= ST_HIGH;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HIGH: if (scl_s_i) begin
          if (cnt_q == CNT_END) begin
            cnt_q <= '0;
            if (op_q == OP_START || op_q == OP_STOP) begin
              sda_oe_q <= (op_q == OP_START);
              st_q     <= ST_TAIL;
            end else if (bit_q == 4'd8) begin
              ack_q    <= !sda_s_i;
              scl_oe_q <= 1'b1;
              done_q   <= 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              sh_q     <= {sh_q[6:0], sda_s_i};
              bit_q    <= bit_q + 1'b1;
              scl_oe_q <= 1'b1;
              st_q     <= ST_LOW;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == CNT_END) begin
            cnt_q    <= '0;
            scl_oe_q <= (op_q == OP_START);
            done_q   <= 1'b1;
            st_q     <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign rdata_o  = sh_q;
  assign ack_o    = ack_q;
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;

  // R4
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_HIGH) && (op_q == OP_WR || op_q == OP_RD) |-> $stable(sda_oe_q));

  // R5
  stretch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HIGH) && !scl_s_i |=> (st_q == ST_HIGH) && $stable(cnt_q));
endmodule

// File: rtl/i2c_boot_seq.sv
module i2c_boot_seq
  import i2c_boot_pkg::*;
#(
  parameter logic [6:0]              DEV_ADDR    = 7'h50,
  parameter int                      BOOT_BYTES  = 4,
  parameter logic [BOOT_BYTES*8-1:0] CFG_DEFAULT = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    eng_busy_i,
  input  logic                    eng_done_i,
  input  logic [7:0]              eng_rdata_i,
  input  logic                    eng_ack_i,
  output logic                    cmd_valid_o,
  output i2c_op_e                 cmd_op_o,
  output logic [7:0]              cmd_wdata_o,
  output logic                    cmd_last_o,
  output logic                    active_o,
  output logic [BOOT_BYTES*8-1:0] cfg_o
);
  localparam int SW = $clog2(BOOT_BYTES + 7);
  localparam logic [SW-1:0] STEP_ADDR = SW'(1);
  localparam logic [SW-1:0] STEP_RD0  = SW'(5);
  localparam logic [SW-1:0] STEP_LAST = SW'(4 + BOOT_BYTES);
  localparam logic [SW-1:0] STEP_STOP = SW'(5 + BOOT_BYTES);

  logic [SW-1:0] step_q;
  logic          active_q, issue_q;

  always_comb begin
    cmd_wdata_o = 8'h00;
    if (step_q == SW'(0) || step_q == SW'(3)) cmd_op_o = OP_START;
    else if (step_q == STEP_STOP)              cmd_op_o = OP_STOP;
    else if (step_q < STEP_RD0)                cmd_op_o = OP_WR;
    else                                       cmd_op_o = OP_RD;
    if (step_q == STEP_ADDR)   cmd_wdata_o = {DEV_ADDR, 1'b0};
    if (step_q == SW'(4))      cmd_wdata_o = {DEV_ADDR, 1'b1};
  end

  assign cmd_last_o  = (step_q == STEP_LAST);
  assign cmd_valid_o = active_q && issue_q && !eng_busy_i;
  assign active_o    = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      issue_q  <= 1'b1;
      step_q   <= '0;
    end else if (active_q) begin
      if (issue_q) begin
        if (!eng_busy_i) issue_q <= 1'b0;
      end else if (eng_done_i) begin
        if (step_q == STEP_STOP) active_q <= 1'b0;
        else begin
          issue_q <= 1'b1;
          // no device: skip to STOP, keep defaults
          step_q  <= (step_q == STEP_ADDR && !eng_ack_i) ? STEP_STOP : step_q + 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < BOOT_BYTES; k++) begin : g_cfg
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= CFG_DEFAULT[k*8 +: 8];
      else if (active_q && !issue_q && eng_done_i && step_q == SW'(5 + k))
        byte_q <= eng_rdata_i;
    end
    assign cfg_o[k*8 +: 8] = byte_q;
  end

  // R2
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> $stable(cfg_o));
endmodule

// File: rtl/i2c_boot_master.sv
module i2c_boot_master
  import i2c_boot_pkg::*;
#(
  parameter int                      HALF_CYC    = 250,
  parameter logic [6:0]              DEV_ADDR    = 7'h50,
  parameter int                      BOOT_BYTES  = 4,
  parameter logic [BOOT_BYTES*8-1:0] CFG_DEFAULT = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    scl_oe_o,
  output logic                    sda_oe_o,
  output logic                    cpu_rst_o,
  output logic [BOOT_BYTES*8-1:0] cfg_o,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic                    last_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  output logic                    ack_o,
  output logic                    done_o,
  output logic                    busy_o
);
  logic [1:0] line_s;
  logic       eng_busy, eng_done, eng_ack, eng_valid, eng_last;
  logic [7:0] eng_rdata, eng_wdata;
  i2c_op_e    eng_op;

  logic       boot_active, boot_valid, boot_last;
  logic [7:0] boot_wdata;
  i2c_op_e    boot_op;

  logic       host_req, host_valid;
  i2c_op_e    host_op;
  logic       done_q;

  i2c_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2c_boot_seq #(
    .DEV_ADDR   (DEV_ADDR),
    .BOOT_BYTES (BOOT_BYTES),
    .CFG_DEFAULT(CFG_DEFAULT)
  ) u_boot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eng_busy_i (eng_busy),
    .eng_done_i (eng_done),
    .eng_rdata_i(eng_rdata),
    .eng_ack_i  (eng_ack),
    .cmd_valid_o(boot_valid),
    .cmd_op_o   (boot_op),
    .cmd_wdata_o(boot_wdata),
    .cmd_last_o (boot_last),
    .active_o   (boot_active),
    .cfg_o      (cfg_o)
  );

  assign host_req   = start_i | stop_i | wr_i | rd_i;
  assign host_valid = !boot_active && !eng_busy && host_req;
  assign host_op    = start_i ? OP_START : stop_i ? OP_STOP : wr_i ? OP_WR : OP_RD;

  assign eng_valid = boot_active ? boot_valid : host_valid;
  assign eng_op    = boot_active ? boot_op    : host_op;
  assign eng_wdata = boot_active ? boot_wdata : wdata_i;
  assign eng_last  = boot_active ? boot_last  : last_i;

  i2c_byte_eng #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(eng_valid),
    .cmd_op_i   (eng_op),
    .cmd_wdata_i(eng_wdata),
    .cmd_last_i (eng_last),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .busy_o     (eng_busy),
    .done_o     (eng_done),
    .rdata_o    (eng_rdata),
    .ack_o      (eng_ack),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        done_q <= 1'b0;
    else if (host_valid)                done_q <= 1'b0;
    else if (eng_done && !boot_active)  done_q <= 1'b1;
  end

  assign cpu_rst_o = boot_active;
  assign done_o    = done_q;
  assign busy_o    = boot_active | eng_busy;
  assign rdata_o   = eng_rdata;
  assign ack_o     = eng_ack;

  // R1
  boot_release_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> !scl_oe_o && !sda_oe_o);

  // R10
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid |=> !done_o && busy_o);
endmodule

// File: tb/tb_i2c_boot_master.sv
module tb_i2c_boot_master;
  localparam int          HALF    = 4;
  localparam int          NB      = 4;
  localparam int          STRETCH = 12;
  localparam logic [31:0] DEF     = 32'h1234_5678;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       start_i = 0, stop_i = 0, wr_i = 0, rd_i = 0, last_i = 0;
  logic [7:0] wdata_i = 0;
  logic       scl_oe, sda_oe, cpu_rst, ack_o, done_o, busy_o;
  logic [7:0] rdata_o;
  logic [31:0] cfg_o;

  logic slv_sda_low = 1'b0;
  int   stretch_cnt = 0;
  bit   present = 1, stretch_en = 0;
  wire  scl_line = !(scl_oe || (stretch_cnt > 0));
  wire  sda_line = !(sda_oe || slv_sda_low);

  i2c_boot_master #(.HALF_CYC(HALF), .DEV_ADDR(7'h50), .BOOT_BYTES(NB), .CFG_DEFAULT(DEF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .cpu_rst_o(cpu_rst), .cfg_o(cfg_o),
    .start_i(start_i), .stop_i(stop_i), .wr_i(wr_i), .rd_i(rd_i), .last_i(last_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o), .done_o(done_o), .busy_o(busy_o)
  );

  int checks = 0, failures = 0;
  logic [10:0] exp_q[$];
  string       exp_tag[$];
  logic [7:0]  mem [8];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic expect_ev(input string r, input logic [10:0] e);
    exp_q.push_back(e);
    exp_tag.push_back(r);
  endtask

  task automatic sb_pop(input logic [10:0] got);
    if (exp_q.size() == 0) begin
      checks++; failures++;
      $display("FAIL R4 unexpected bus event act=%h exp=none", got);
    end else begin
      string t;
      logic [10:0] e;
      t = exp_tag.pop_front();
      e = exp_q.pop_front();
      chk(t, {21'd0, got}, {21'd0, e});
    end
  endtask

  localparam logic [10:0] EV_START = {2'd1, 9'd0};
  localparam logic [10:0] EV_STOP  = {2'd2, 9'd0};
  function automatic logic [10:0] ev_byte(input logic a, input logic [7:0] d);
    return {2'd3, a, d};
  endfunction

  // bus monitor and EEPROM slave, sampled on the falling clock edge
  logic       scl_p = 1, sda_p = 1, scl_n, sda_n;
  logic       in_xfer = 0, skip_fall = 0, addressed = 0, rw_bit = 0, rd_phase = 0, ackm = 0;
  logic [7:0] shm = 0;
  logic [2:0] ptr = 0;
  int         bitc = 0, byte_idx = 0, high_len = 0;

  always @(negedge clk) begin
    scl_n = scl_line;
    sda_n = sda_line;
    if (stretch_cnt > 0) stretch_cnt--;
    if (scl_p && scl_n && sda_p && !sda_n) begin
      sb_pop(EV_START);
      in_xfer = 1; skip_fall = 1; bitc = 0; byte_idx = 0;
      addressed = 0; rd_phase = 0; slv_sda_low = 0;
    end else if (scl_p && scl_n && !sda_p && sda_n) begin
      if (in_xfer) sb_pop(EV_STOP);
      in_xfer = 0; slv_sda_low = 0;
    end
    if (!scl_p && scl_n) begin
      high_len = 1;
      if (in_xfer) begin
        if (bitc < 8) shm = {shm[6:0], sda_n};
        else ackm = !sda_n;
      end
    end else if (scl_p && scl_n) high_len++;
    if (scl_p && !scl_n && in_xfer) begin
      chk("R5 scl high pulse length", {31'd0, high_len >= HALF}, 32'd1);
      if (skip_fall) skip_fall = 0;
      else if (bitc == 8) begin
        sb_pop(ev_byte(ackm, shm));
        bitc = 0;
        byte_idx++;
        if (rd_phase) begin ptr = ptr + 1'b1; rd_phase = ackm; end
        else rd_phase = addressed && rw_bit;
      end else bitc++;
      if (stretch_en) stretch_cnt = STRETCH;
      if (bitc == 8) begin
        if (!rd_phase) begin
          if (byte_idx == 0) begin
            addressed = present && (shm[7:1] == 7'h50);
            rw_bit = shm[0];
          end else if (byte_idx == 1 && addressed && !rw_bit) ptr = shm[2:0];
          slv_sda_low = addressed;
        end else slv_sda_low = 0;
      end else slv_sda_low = rd_phase && !mem[ptr][7-bitc];
    end
    scl_p = scl_n;
    sda_p = sda_n;
  end

  task automatic host_op(input int op, input logic [7:0] d, input logic lst);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    case (op)
      0: start_i = 1;
      1: stop_i = 1;
      2: wr_i = 1;
      default: rd_i = 1;
    endcase
    wdata_i = d;
    last_i = lst;
    @(negedge clk);
    start_i = 0; stop_i = 0; wr_i = 0; rd_i = 0;
    chk("R10 done cleared after accept", {31'd0, done_o}, 32'd0);
    while (!done_o) @(negedge clk);
    chk("R10 idle when done", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    mem[0] = 8'h81; mem[1] = 8'h3C; mem[2] = 8'hE7; mem[3] = 8'h12;
    mem[4] = 8'h6D; mem[5] = 8'hF0; mem[6] = 8'h0F; mem[7] = 8'hA5;

    repeat (3) @(negedge clk);
    chk("R1 cpu reset held", {31'd0, cpu_rst}, 32'd1);
    chk("R1 scl released", {31'd0, scl_oe}, 32'd0);
    chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
    chk("R1 busy in reset", {31'd0, busy_o}, 32'd1);

    // R2 boot read expectation
    expect_ev("R2 start", EV_START);
    expect_ev("R2 addr write", ev_byte(1, 8'hA0));
    expect_ev("R2 word addr", ev_byte(1, 8'h00));
    expect_ev("R2 repeated start", EV_START);
    expect_ev("R2 addr read", ev_byte(1, 8'hA1));
    for (int k = 0; k < NB; k++) expect_ev("R2 boot byte", ev_byte(k != NB - 1, mem[k]));
    expect_ev("R2 stop", EV_STOP);
    rst_n = 1;

    // R9 commands during boot must not reach the bus
    repeat (30) @(negedge clk);
    wr_i = 1; start_i = 1; wdata_i = 8'h5A;
    repeat (2) @(negedge clk);
    wr_i = 0; start_i = 0;

    while (cpu_rst) @(negedge clk);
    chk("R2 cfg loaded", cfg_o, {mem[3], mem[2], mem[1], mem[0]});
    chk("R2 all boot events seen", exp_q.size(), 0);
    chk("R9 done untouched by boot", {31'd0, done_o}, 32'd0);
    chk("R1 lines released at handover", {30'd0, scl_oe, sda_oe}, 32'd0);

    // host transfers with clock stretching
    stretch_en = 1;
    expect_ev("R8 host start", EV_START);
    host_op(0, 8'h00, 0);
    expect_ev("R6 write addr", ev_byte(1, 8'hA0));
    host_op(2, 8'hA0, 0);
    chk("R6 ack reported", {31'd0, ack_o}, 32'd1);
    expect_ev("R6 write word addr", ev_byte(1, 8'h02));
    host_op(2, 8'h02, 0);
    expect_ev("R8 repeated start", EV_START);
    host_op(0, 8'h00, 0);
    expect_ev("R6 write read addr", ev_byte(1, 8'hA1));
    host_op(2, 8'hA1, 0);
    expect_ev("R7 read with ack", ev_byte(1, mem[2]));
    host_op(3, 8'h00, 0);
    chk("R7 rdata first", {24'd0, rdata_o}, {24'd0, mem[2]});
    expect_ev("R7 read with nack", ev_byte(0, mem[3]));
    host_op(3, 8'h00, 1);
    chk("R7 rdata last", {24'd0, rdata_o}, {24'd0, mem[3]});
    expect_ev("R8 host stop", EV_STOP);
    host_op(1, 8'h00, 0);
    chk("R8 lines released after stop", {30'd0, scl_oe, sda_oe}, 32'd0);

    // write to an absent address: NACK
    stretch_en = 0;
    expect_ev("R8 start nack case", EV_START);
    host_op(0, 8'h00, 0);
    expect_ev("R6 nack byte", ev_byte(0, 8'h78));
    host_op(2, 8'h78, 0);
    chk("R6 nack reported", {31'd0, ack_o}, 32'd0);
    expect_ev("R8 stop nack case", EV_STOP);
    host_op(1, 8'h00, 0);
    repeat (5) @(negedge clk);
    chk("R4 all host events seen", exp_q.size(), 0);

    // R3 boot without a device
    rst_n = 0;
    present = 0;
    repeat (3) @(negedge clk);
    expect_ev("R3 start", EV_START);
    expect_ev("R3 addr nack", ev_byte(0, 8'hA0));
    expect_ev("R3 stop", EV_STOP);
    rst_n = 1;
    @(negedge clk);
    while (cpu_rst) @(negedge clk);
    chk("R3 defaults kept", cfg_o, DEF);
    chk("R3 all events seen", exp_q.size(), 0);

    finish_run();
  end
endmodule